// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Zero-Turnaround Bus

This block is a synchronous single-port memory whose data bus can switch between reads and writes on every clock with no idle cycles. A command (enable, write select, per-lane write enables and address) is registered on a rising edge. The write data for that command arrives on a later edge, and read data comes back in the same later bus slot. Because reads and writes use the same slot, the external data bus sees one fixed schedule, and commands of either kind can follow each other freely.

A static mode input, sampled only while reset is held, selects one of two latencies. In pipelined mode write data is taken two edges after its command, and read data is driven from a register loaded one edge after the command. In flow-through mode write data is taken on the next edge, and read data is driven combinationally right after the command edge. Writes reach the array only once their data has arrived. A read that follows a write to the same address therefore gets the pending bytes forwarded, merged lane by lane with the stored word. Data ports are plain fixed-latency pins with no valid/ready handshake: the bus schedule is fixed, so there is no back-pressure and the user must supply write data in its slot.

Top module: `lwsram_top`

## Requirements
- R1: The word is split into NL = DW/LW lanes, where lane i covers data bits [LW*i+LW-1 : LW*i] and is written only if bit i of the write's lane enables is 1. Lanes with a 0 bit keep their stored contents.
- R2: A write command whose lane enables are all 0 leaves the array unchanged.
- R3: In pipelined mode (mode input 0), a write command registered on edge k takes its data from `wdata` on edge k+2.
- R4: In pipelined mode, a read registered on edge k drives its data on `rdata` from edge k+1 until edge k+2. `rdata` holds its value through cycles whose slot carries no read, and it is 0 after reset.
- R5: In flow-through mode (mode input 1), a write command registered on edge k takes its data from `wdata` on edge k+1.
- R6: In flow-through mode, a read registered on edge k drives its data on `rdata` from just after edge k until edge k+1.
- R7: A read returns the effect of every write command registered before it, including a write whose data has not yet been stored. Enabled lanes come from the pending data and disabled lanes come from the array.
- R8: With `cmd_en` low on an edge, no command is registered and the other command inputs are ignored. Writes already issued still take their data and complete on schedule.
- R9: The mode input is sampled only while `rst_n` is low. Changes to it after reset have no effect.
- R10: Reads and writes may be issued on consecutive edges in any order with no idle cycle, and every read still returns correct data.
- R11: Reset cancels commands in flight: a write whose data slot had not yet come does not change the array. Array contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all registers on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flow_mode | input | 1 | Latency select, 0 pipelined, 1 flow-through; sampled during reset |
| cmd_en | input | 1 | Command enable for this edge |
| cmd_we | input | 1 | 1 = write command, 0 = read command |
| cmd_be | input | NL | Per-lane write enables, bit i for lane i |
| cmd_addr | input | AW | Word address |
| wdata | input | DW | Write data, sampled in the write's data slot |
| rdata | output | DW | Read data, valid in the read's data slot |

## Verification
A wrong command pipeline register shows up as wrong read data, or as a write landing at the wrong address or with the wrong lanes. The read data is wrong one slot later in flow-through mode and two slots later in pipelined mode. A wrong forwarding decision shows only when a read lands on the address of the write just before it, so the random streams keep most addresses inside a window of eight words to make such hits frequent. Array corruption surfaces at the next read of that word, which may come much later. For this reason every address is written first, and every read is compared against a reference that replays all earlier writes.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  typedef enum logic {
    MODE_PIPE = 1'b0,
    MODE_FLOW = 1'b1
  } lws_mode_e;
endpackage

// File: rtl/lwsram_lane_merge.sv
module lwsram_lane_merge #(
  parameter int DW = 36,
  parameter int LW = 9,
  localparam int NL = DW / LW
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] upd,
  input  logic [NL-1:0] sel,
  output logic [DW-1:0] merged
);
  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign merged[l*LW +: LW] = sel[l] ? upd[l*LW +: LW] : base[l*LW +: LW];
  end
endmodule

// File: rtl/lwsram_cmd_pipe.sv
module lwsram_cmd_pipe #(
  parameter int NL = 4,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_en,
  input  logic          in_we,
  input  logic [NL-1:0] in_be,
  input  logic [AW-1:0] in_addr,
  output logic          s1_valid,
  output logic          s1_we,
  output logic [NL-1:0] s1_be,
  output logic [AW-1:0] s1_addr,
  output logic          s2_valid,
  output logic          s2_we,
  output logic [NL-1:0] s2_be,
  output logic [AW-1:0] s2_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_we    <= 1'b0;
      s1_be    <= '0;
      s1_addr  <= '0;
      s2_valid <= 1'b0;
      s2_we    <= 1'b0;
      s2_be    <= '0;
      s2_addr  <= '0;
    end else begin
      s1_valid <= in_en;
      s1_we    <= in_we;
      s1_be    <= in_be;
      s1_addr  <= in_addr;
      s2_valid <= s1_valid;
      s2_we    <= s1_we;
      s2_be    <= s1_be;
      s2_addr  <= s1_addr;
    end
  end
endmodule

// File: rtl/lwsram_store.sv
module lwsram_store #(
  parameter int DW    = 36,
  parameter int LW    = 9,
  parameter int DEPTH = 256,
  localparam int NL = DW / LW,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [NL-1:0] wr_be,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  for (genvar l = 0; l < NL; l++) begin : g_bank
    logic [LW-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[l]) bank[wr_addr] <= wr_data[l*LW +: LW];
    end
    assign rd_data[l*LW +: LW] = bank[rd_addr];
  end
endmodule

// File: rtl/lwsram_top.sv
module lwsram_top
  import lwsram_pkg::*;
#(
  parameter int DW    = 36,
  parameter int LW    = 9,
  parameter int DEPTH = 256,
  localparam int NL = DW / LW,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flow_mode,
  input  logic          cmd_en,
  input  logic          cmd_we,
  input  logic [NL-1:0] cmd_be,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  lws_mode_e     mode_q;
  logic          s1_valid, s1_we, s2_valid, s2_we;
  logic [NL-1:0] s1_be, s2_be;
  logic [AW-1:0] s1_addr, s2_addr;
  logic          commit_en;
  logic [AW-1:0] commit_addr;
  logic [NL-1:0] commit_be;
  logic [DW-1:0] arr_word, fwd_word, rdata_q;
  logic          fwd_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= lws_mode_e'(flow_mode);
  end

  lwsram_cmd_pipe #(.NL(NL), .AW(AW)) pipe_i (
    .clk(clk), .rst_n(rst_n),
    .in_en(cmd_en), .in_we(cmd_we), .in_be(cmd_be), .in_addr(cmd_addr),
    .s1_valid(s1_valid), .s1_we(s1_we), .s1_be(s1_be), .s1_addr(s1_addr),
    .s2_valid(s2_valid), .s2_we(s2_we), .s2_be(s2_be), .s2_addr(s2_addr)
  );

  // The write whose data is on wdata this cycle is in stage 1 (flow) or stage 2 (pipe).
  always_comb begin
    if (mode_q == MODE_FLOW) begin
      commit_en   = s1_valid && s1_we;
      commit_addr = s1_addr;
      commit_be   = s1_be;
    end else begin
      commit_en   = s2_valid && s2_we;
      commit_addr = s2_addr;
      commit_be   = s2_be;
    end
  end

  lwsram_store #(.DW(DW), .LW(LW), .DEPTH(DEPTH)) store_i (
    .clk(clk), .wr_en(commit_en), .wr_addr(commit_addr), .wr_be(commit_be),
    .wr_data(wdata), .rd_addr(s1_addr), .rd_data(arr_word)
  );

  // Pipelined read loads on the same edge that commits the previous write: forward it.
  assign fwd_hit = s2_valid && s2_we && (s2_addr == s1_addr);

  lwsram_lane_merge #(.DW(DW), .LW(LW)) fwd_i (
    .base(arr_word), .upd(wdata), .sel(fwd_hit ? s2_be : '0), .merged(fwd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (mode_q == MODE_PIPE && s1_valid && !s1_we) rdata_q <= fwd_word;
  end

  assign rdata = (mode_q == MODE_FLOW) ? arr_word : rdata_q;
endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk #(
  parameter int DW = 36,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_q,
  input logic          cmd_en,
  input logic          s1_valid,
  input logic          s1_we,
  input logic [AW-1:0] s1_addr,
  input logic          s2_valid,
  input logic          s2_we,
  input logic [AW-1:0] s2_addr,
  input logic [DW-1:0] rdata
);
  assert_idle_no_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_en |=> !s1_valid);

  assert_write_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && s1_valid && s1_we) |=> (s2_valid && s2_we && s2_addr == $past(s1_addr)));

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q));

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !(s1_valid && !s1_we)) |=> $stable(rdata));

  assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!s1_valid && !s2_valid));
endmodule

bind lwsram_top lwsram_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .cmd_en(cmd_en),
  .s1_valid(s1_valid), .s1_we(s1_we), .s1_addr(s1_addr),
  .s2_valid(s2_valid), .s2_we(s2_we), .s2_addr(s2_addr), .rdata(rdata)
);

// File: tb/lwsram_top_tb_top.sv
module lwsram_top_tb_top;
  localparam int DW = 36, LW = 9, DEPTH = 256;
  localparam int NL = DW / LW, AW = $clog2(DEPTH);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, flow_mode = 1'b0, cmd_en = 1'b0, cmd_we = 1'b0;
  logic [NL-1:0] cmd_be = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  lwsram_top #(.DW(DW), .LW(LW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .cmd_en(cmd_en),
    .cmd_we(cmd_we), .cmd_be(cmd_be), .cmd_addr(cmd_addr),
    .wdata(wdata), .rdata(rdata)
  );

  int n_chk = 0, n_bad = 0, slot = 0, lat = 2;
  string cur_tag = "";
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] last_rd = '0;
  logic          h_en [4], h_we [4];
  logic [NL-1:0] h_be [4];
  logic [AW-1:0] h_addr [4];

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (slot %0d)", req, act, exp, slot);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                           input logic [NL-1:0] be);
    logic [DW-1:0] r = old;
    for (int l = 0; l < NL; l++) if (be[l]) r[l*LW +: LW] = nw[l*LW +: LW];
    return r;
  endfunction

  // One bus slot: check the read due now, then drive command and due write data.
  task automatic step(input logic en, input logic we, input logic [NL-1:0] be,
                      input logic [AW-1:0] addr);
    int p, q;
    string tag;
    logic [DW-1:0] exp, wd;
    logic [63:0] rnd;
    @(negedge clk);
    p = (slot - lat) & 3;
    q = (slot - lat - 1) & 3;
    if (h_en[p] && !h_we[p]) begin
      exp = ref_mem[h_addr[p]];
      if (cur_tag != "") tag = cur_tag;
      else if (h_en[q] && h_we[q] && h_addr[q] == h_addr[p]) tag = "R7";
      else tag = (lat == 2) ? "R3 R4" : "R5 R6";
      check(tag, rdata, exp);
      last_rd = exp;
    end else if (lat == 2) begin
      check("R4 hold", rdata, last_rd);
    end
    rnd = {$urandom(), $urandom()};
    wd = rnd[DW-1:0];
    if (h_en[p] && h_we[p]) ref_mem[h_addr[p]] = merge(ref_mem[h_addr[p]], wd, h_be[p]);
    wdata = wd;
    cmd_en = en; cmd_we = we; cmd_be = be; cmd_addr = addr;
    h_en[slot & 3] = en; h_we[slot & 3] = we; h_be[slot & 3] = be; h_addr[slot & 3] = addr;
    slot++;
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_n = 1'b0; cmd_en = 1'b0; flow_mode = m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) h_en[i] = 1'b0;
    lat = m ? 1 : 2;
    last_rd = '0;
  endtask

  task automatic rand_steps(input int n);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      a = ($urandom() % 4 == 0) ? AW'($urandom()) : AW'($urandom() % 8);
      step(($urandom() % 8) != 0, 1'(($urandom())), NL'($urandom()), a);
    end
  endtask

  task automatic fill_all();
    for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b1, '1, AW'(a));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 4; i++) h_en[i] = 1'b0;
    do_reset(1'b0);
    @(negedge clk);
    check("R11 reset rdata", rdata, '0);
    fill_all();
    step(1'b0, 1'b0, '0, '0); step(1'b0, 1'b0, '0, '0);

    // R1: partial lane masks
    cur_tag = "R1";
    step(1'b1, 1'b1, 4'b0101, 8'd3); step(1'b0, 1'b0, '0, '0); step(1'b0, 1'b0, '0, '0);
    step(1'b1, 1'b0, '0, 8'd3);
    step(1'b1, 1'b1, 4'b1010, 8'd3); step(1'b0, 1'b0, '0, '0); step(1'b0, 1'b0, '0, '0);
    step(1'b1, 1'b0, '0, 8'd3); step(1'b0, 1'b0, '0, '0); step(1'b0, 1'b0, '0, '0);
    // R2: empty mask
    cur_tag = "R2";
    step(1'b1, 1'b1, 4'b0000, 8'd4); step(1'b0, 1'b0, '0, '0); step(1'b0, 1'b0, '0, '0);
    step(1'b1, 1'b0, '0, 8'd4); step(1'b0, 1'b0, '0, '0); step(1'b0, 1'b0, '0, '0);
    // R7: read right behind a partial write, both latencies exercised later too
    cur_tag = "R7";
    step(1'b1, 1'b1, 4'b0110, 8'd9); step(1'b1, 1'b0, '0, 8'd9);
    step(1'b1, 1'b1, 4'b1001, 8'd9); step(1'b1, 1'b0, '0, 8'd9);
    step(1'b0, 1'b0, '0, '0); step(1'b0, 1'b0, '0, '0);
    // R8: idle edges with junk controls, pending write still completes
    cur_tag = "R8";
    step(1'b1, 1'b1, 4'b1111, 8'd11);
    step(1'b0, 1'b1, 4'b1111, 8'd11); step(1'b0, 1'b1, 4'b1111, 8'd12);
    step(1'b0, 1'b0, '0, '0);
    step(1'b1, 1'b0, '0, 8'd11); step(1'b1, 1'b0, '0, 8'd12);
    step(1'b0, 1'b0, '0, '0); step(1'b0, 1'b0, '0, '0);
    // R10: strict alternation with no gaps
    cur_tag = "R10";
    for (int i = 0; i < 40; i++) step(1'b1, 1'(i % 2 == 0), NL'($urandom()), AW'(i / 2 % 3));
    // R9: mode pin changes after reset must not alter latency
    flow_mode = 1'b1;
    cur_tag = "R9";
    rand_steps(60);
    cur_tag = "";
    rand_steps(600);
    // R11: a write in flight is dropped by reset
    step(1'b0, 1'b0, '0, '0); step(1'b0, 1'b0, '0, '0);
    step(1'b1, 1'b1, '1, 8'd20);
    do_reset(1'b1);
    cur_tag = "R11";
    step(1'b1, 1'b0, '0, 8'd20); step(1'b0, 1'b0, '0, '0);

    // flow-through mode
    cur_tag = "R5 R6";
    step(1'b1, 1'b1, 4'b0011, 8'd30); step(1'b1, 1'b0, '0, 8'd30);
    step(1'b1, 1'b1, 4'b1100, 8'd30); step(1'b1, 1'b0, '0, 8'd30);
    step(1'b0, 1'b0, '0, '0);
    cur_tag = "R10";
    for (int i = 0; i < 40; i++) step(1'b1, 1'(i % 3 != 2), NL'($urandom()), AW'(i % 4));
    cur_tag = "";
    rand_steps(800);
    step(1'b0, 1'b0, '0, '0); step(1'b0, 1'b0, '0, '0); step(1'b0, 1'b0, '0, '0);
    finish_run();
  end
endmodule